// File: doc/BRIEF.md
# Processor Status Word with Banked Stack Pointers

This unit holds a processor's status word: six condition and control flags, three system control bits (a trace bit and two divide-step bits) and a 5-bit interrupt level mask. It also keeps two stack pointers, one for system mode and one for user mode. Both share a single general-register slot, R15. The stack-select flag chooses which of the two is live in R15. The other one sits in a saved copy.

Software and the surrounding core reach the state through several ports. A full-word port reads and writes the packed status word. Two byte-wide ports access the condition byte and the system byte. A dedicated-register port accesses the system or user stack pointer by name, wherever that pointer currently lives. A general-register port reads and writes the live R15. When the stack-select flag changes, the unit moves the live pointer into its saved copy and brings the other pointer into R15 in the same clock edge.

Top module: `psw_unit`

## Requirements
- R1: The condition byte reads with C at bit 0, V at bit 1, Z at bit 2, N at bit 3, interrupt-enable I at bit 4 and stack-select S at bit 5. Bits 7:6 read as zero. A write keeps only bits 5:0.
- R2: The system byte reads with trace T at bit 0, D0 at bit 1 and D1 at bit 2. Bits 7:3 read as zero. A write keeps only bits 2:0.
- R3: The full status word carries the condition byte in bits 5:0, the system bits in bits 10:8 and the level mask in bits 20:16. Every other bit reads as zero.
- R4: When the stored level mask is 16 or more and a value below 16 is written, the mask becomes the written value plus 16. Otherwise the written value is stored as given.
- R5: When S goes from 0 to 1, R15 is saved as the user pointer and R15 takes the saved system pointer. When S goes from 1 to 0, R15 is saved as the system pointer and R15 takes the saved user pointer.
- R6: Writing S with its present value moves no stack pointer.
- R7: On the dedicated port, select 0 names the system pointer and select 1 names the user pointer. The named pointer is R15 when it is the active one (system with S=1, user with S=0), and its saved copy otherwise. This holds for both reads and writes.
- R8: A full-word write updates the flags, the system bits and the mask in one edge. If that write changes S, it also performs the stack swap.
- R9: After reset all flags and system bits are clear, S is 1, the level mask is 15, and R15 and both saved pointers are zero.
- R10: If R15 is written on the general-register port in the same cycle as an S change, the newly written value is the one saved.
- R11: When the full-word port and a byte port write in the same cycle, the full-word value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Full status word write strobe |
| sw_wdata | input | 32 | Full status word write data |
| sw_rdata | output | 32 | Packed status word |
| cc_we | input | 1 | Condition byte write strobe |
| cc_wdata | input | 8 | Condition byte write data |
| cc_rdata | output | 8 | Condition byte |
| sys_we | input | 1 | System byte write strobe |
| sys_wdata | input | 8 | System byte write data |
| sys_rdata | output | 8 | System byte |
| dsp_we | input | 1 | Dedicated stack pointer write strobe |
| dsp_sel | input | 1 | 0 = system pointer, 1 = user pointer |
| dsp_wdata | input | SP_W | Dedicated stack pointer write data |
| dsp_rdata | output | SP_W | Selected stack pointer |
| sp_we | input | 1 | R15 write strobe from the register file |
| sp_wdata | input | SP_W | R15 write data |
| sp_live | output | SP_W | Live R15 value |

## Verification
The swap is tried in both directions with distinct pointer values. This shows whether each pointer lands in the right saved copy, or whether the two are crossed or lost. A rewrite of S to its present value separates a true edge detection from a swap on every write. A full-word write of S issued together with an R15 write shows whether the swap saves the old or the new R15. The mask is written with an in-range value from below 16, then with a lower-half value from above 16, then with an upper-half value. These three writes separate the one-way rule from a plain store and from a saturating variant.

// File: rtl/psw_unit.sv
module psw_unit #(
  parameter int SP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_we,
  input  logic [31:0]     sw_wdata,
  output logic [31:0]     sw_rdata,
  input  logic            cc_we,
  input  logic [7:0]      cc_wdata,
  output logic [7:0]      cc_rdata,
  input  logic            sys_we,
  input  logic [7:0]      sys_wdata,
  output logic [7:0]      sys_rdata,
  input  logic            dsp_we,
  input  logic            dsp_sel,
  input  logic [SP_W-1:0] dsp_wdata,
  output logic [SP_W-1:0] dsp_rdata,
  input  logic            sp_we,
  input  logic [SP_W-1:0] sp_wdata,
  output logic [SP_W-1:0] sp_live
);
  logic [5:0]      ccr, ccr_nx;
  logic [2:0]      scr, scr_nx;
  logic [4:0]      ilm, ilm_nx;
  logic [SP_W-1:0] r15, ssp, usp;
  logic [SP_W-1:0] r15_pre, ssp_pre, usp_pre;
  logic            s_now, s_nx, dsp_live;

  assign s_now    = ccr[5];
  assign dsp_live = dsp_sel ? ~s_now : s_now;

  always_comb begin
    ccr_nx = sw_we ? sw_wdata[5:0]  : cc_we  ? cc_wdata[5:0]  : ccr;
    scr_nx = sw_we ? sw_wdata[10:8] : sys_we ? sys_wdata[2:0] : scr;
    ilm_nx = sw_we ? {sw_wdata[20] | ilm[4], sw_wdata[19:16]} : ilm;
    s_nx   = ccr_nx[5];

    r15_pre = r15;
    ssp_pre = ssp;
    usp_pre = usp;
    if (dsp_we) begin
      if (dsp_live)     r15_pre = dsp_wdata;
      else if (dsp_sel) usp_pre = dsp_wdata;
      else              ssp_pre = dsp_wdata;
    end
    if (sp_we) r15_pre = sp_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr <= 6'h20;
      scr <= '0;
      ilm <= 5'd15;
      r15 <= '0;
      ssp <= '0;
      usp <= '0;
    end else begin
      ccr <= ccr_nx;
      scr <= scr_nx;
      ilm <= ilm_nx;
      if (s_nx && !s_now) begin
        usp <= r15_pre;
        r15 <= ssp_pre;
        ssp <= ssp_pre;
      end else if (!s_nx && s_now) begin
        ssp <= r15_pre;
        r15 <= usp_pre;
        usp <= usp_pre;
      end else begin
        r15 <= r15_pre;
        ssp <= ssp_pre;
        usp <= usp_pre;
      end
    end
  end

  assign cc_rdata  = {2'b00, ccr};
  assign sys_rdata = {5'b0, scr};
  assign sw_rdata  = {11'b0, ilm, 5'b0, scr, 2'b00, ccr};
  assign sp_live   = r15;
  assign dsp_rdata = dsp_live ? r15 : (dsp_sel ? usp : ssp);
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk #(
  parameter int SP_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sp_we,
  input logic            dsp_we,
  input logic            dsp_sel,
  input logic [SP_W-1:0] dsp_rdata,
  input logic [SP_W-1:0] sp_live,
  input logic [7:0]      cc_rdata,
  input logic [31:0]     sw_rdata
);
  AST_MASK_UPPER_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rdata[20] |=> sw_rdata[20]); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata[31:21] == 0) && (sw_rdata[15:11] == 0) && (sw_rdata[7:6] == 0)); // R3
  AST_SWAP_TO_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cc_rdata[5]) && $past(!sp_we && !dsp_we && !dsp_sel)) |-> sp_live == $past(dsp_rdata)); // R5
  AST_SWAP_TO_USR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cc_rdata[5]) && $past(!sp_we && !dsp_we && dsp_sel)) |-> sp_live == $past(dsp_rdata)); // R5
  AST_NO_SWAP_SAME_S: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cc_rdata[5]) && $past(!sp_we && !dsp_we)) |-> $stable(sp_live)); // R6
endmodule

bind psw_unit psw_unit_chk #(.SP_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sp_we(sp_we), .dsp_we(dsp_we), .dsp_sel(dsp_sel),
  .dsp_rdata(dsp_rdata), .sp_live(sp_live), .cc_rdata(cc_rdata), .sw_rdata(sw_rdata)
);

// File: tb/psw_unit_test.sv
module psw_unit_test;
  localparam int W = 32;
  logic clk = 0, rst_n = 0;
  logic sw_we = 0, cc_we = 0, sys_we = 0, dsp_we = 0, dsp_sel = 0, sp_we = 0;
  logic [31:0] sw_wdata = 0, sw_rdata;
  logic [7:0] cc_wdata = 0, cc_rdata, sys_wdata = 0, sys_rdata;
  logic [W-1:0] dsp_wdata = 0, dsp_rdata, sp_wdata = 0, sp_live;
  int runs = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  psw_unit #(.SP_W(W)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    sw_we = 0; cc_we = 0; sys_we = 0; dsp_we = 0; sp_we = 0; dsp_sel = 0;
    #3;
  endtask

  task automatic rd_dsp(input logic sel, output logic [W-1:0] v);
    dsp_sel = sel; #1; v = dsp_rdata; dsp_sel = 0; #1;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    chk("R9 word", sw_rdata, 32'h000F_0020);
    chk("R9 r15", sp_live, 0);
    rd_dsp(1, v); chk("R9 usp", v, 0);
  endtask

  task automatic t_cc();
    cc_we = 1; cc_wdata = 8'hFF; tick();
    chk("R1 mask6", cc_rdata, 8'h3F);
    cc_we = 1; cc_wdata = 8'hE0; tick();
    chk("R1 clear", cc_rdata, 8'h20);
  endtask

  task automatic t_sys();
    sys_we = 1; sys_wdata = 8'hFD; tick();
    chk("R2 mask3", sys_rdata, 8'h05);
  endtask

  task automatic t_mask();
    sw_we = 1; sw_wdata = 32'h0005_0020; tick();
    chk("R4 low ok", sw_rdata, 32'h0005_0020);
    sw_we = 1; sw_wdata = 32'h001F_0020; tick();
    chk("R4 up", sw_rdata[20:16], 5'd31);
    sw_we = 1; sw_wdata = 32'h0003_0020; tick();
    chk("R4 no drop", sw_rdata[20:16], 5'd19);
    sw_we = 1; sw_wdata = 32'h0014_0020; tick();
    chk("R4 upper", sw_rdata, 32'h0014_0020);
    sw_we = 1; sw_wdata = 32'hFFFF_FFFF; tick();
    chk("R3 layout", sw_rdata, 32'h001F_073F);
    chk("R8 sys", sys_rdata, 8'h07);
  endtask

  task automatic t_swap();
    logic [W-1:0] v;
    cc_we = 1; cc_wdata = 8'h20; tick();
    sp_we = 1; sp_wdata = 32'hA; tick();
    dsp_we = 1; dsp_sel = 1; dsp_wdata = 32'hB; tick();
    rd_dsp(1, v); chk("R7 usp saved", v, 32'hB);
    rd_dsp(0, v); chk("R7 ssp live", v, 32'hA);
    cc_we = 1; cc_wdata = 8'h00; tick();
    chk("R5 down r15", sp_live, 32'hB);
    rd_dsp(0, v); chk("R5 down ssp", v, 32'hA);
    cc_we = 1; cc_wdata = 8'h20; tick();
    chk("R5 up r15", sp_live, 32'hA);
    rd_dsp(1, v); chk("R5 up usp", v, 32'hB);
  endtask

  task automatic t_same_s();
    cc_we = 1; cc_wdata = 8'h21; tick();
    chk("R6 r15", sp_live, 32'hA);
  endtask

  task automatic t_dsp_alias();
    logic [W-1:0] v;
    dsp_we = 1; dsp_sel = 0; dsp_wdata = 32'h55; tick();
    chk("R7 live write", sp_live, 32'h55);
    rd_dsp(1, v); chk("R7 usp kept", v, 32'hB);
  endtask

  task automatic t_word_swap();
    logic [W-1:0] v;
    sp_we = 1; sp_wdata = 32'h77; sw_we = 1; sw_wdata = 32'h0000_0000; tick();
    chk("R8 r15", sp_live, 32'hB);
    rd_dsp(0, v); chk("R10 new saved", v, 32'h77);
  endtask

  task automatic t_prio();
    cc_we = 1; cc_wdata = 8'h1F; sw_we = 1; sw_wdata = 32'h0000_0001; tick();
    chk("R11 word wins", cc_rdata, 8'h01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; #3;
    t_reset(); t_cc(); t_sys(); t_mask(); t_swap();
    t_same_s(); t_dsp_alias(); t_word_swap(); t_prio();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule